// File: doc/BRIEF.md
# Add-Only Memory Command Controller

This block is the memory-command layer of a single-wire add-only memory. It becomes active once the device has been selected. A time-slot layer below it presents each received byte with a strobe and asks for each byte to be sent back with a request. The block decodes one command byte and then a two-byte start address. It serves a 128-byte one-time-programmable data array and an 8-byte status array. Both arrays are modelled as registers whose bits can only move from 1 to 0.

Each command first returns a CRC8 of what the bus master has sent. Read commands then stream bytes with framing CRCs in the right places. Write commands run as a chain of passes: take a data byte, return a CRC, wait for a program pulse, return the stored byte for verification, and move to the next address. Programming ANDs the scratchpad byte into the addressed location, so a stored byte is the AND of every byte ever programmed there. A bus reset abandons whatever sequence is in progress.

Top module: `otp_cmd_ctrl`

## Requirements
- R1: Command codes are F0h (stream the data array), C3h (stream the data array with a CRC after each 32-byte page), AAh (stream the status array), 0Fh (program data) and 55h (program status). Any other command byte makes the block return FFh for every requested byte and ignore received bytes until a bus reset.
- R2: The CRC8 uses x^8+x^5+x^4+1. It processes bits LSB first and starts from 00h. After the command byte, the address low byte and the address high byte, the first requested byte is the CRC8 of those three bytes. For read commands the address bytes are used as received.
- R3: F0h returns data bytes from the start address through address 127. The next byte is the CRC8 of the data bytes returned, starting again from 00h after the header CRC. After that the block returns FFh. A start address of 128 or more returns FFh straight after the header CRC.
- R4: C3h returns data bytes up to the end of the current 32-byte page. It then returns the CRC8 of the bytes read within that page and continues at the next page. After the CRC of page 3 it returns FFh.
- R5: AAh returns status bytes from the start address through byte 7, then their CRC8, then FFh. Status bytes 0 to 6 start at FFh. Byte 7 always reads 00h.
- R6: For write commands the header CRC covers the command, the masked address and the first data byte, and is returned after that data byte. Masking clears all address bits above bit 6 for data writes and above bit 2 for status writes.
- R7: A program pulse in the wait-for-pulse state ANDs the scratchpad into the addressed byte. A program pulse in any other state has no effect.
- R8: After the pulse, the next requested byte is the stored byte, and the address always increments. On each later pass the CRC register is loaded with the new address low byte, and then the new data byte is shifted in. After the last address of the field has been verified, the block returns FFh.
- R9: If bit p of status byte 0 is 0, data writes to page p (addresses 32p to 32p+31) leave the array unchanged. Reads of that page still work.
- R10: Status bytes 1 to 4 are page-redirection values. FFh means the page is valid; any other value is the one's complement of the replacement page. The hardware ignores them, so data writes to a redirected page still program.
- R11: A bus reset returns the block to waiting for a command. Any tx request in the same cycle gets no response, and a read cut short never produces its trailing CRC.
- R12: Every tx request that does not coincide with a bus reset is answered with tx_valid one cycle later. A request in a state that has nothing to send returns FFh and leaves the state unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset; restores the arrays to their unprogrammed values |
| bus_reset | input | 1 | Single-wire bus reset seen by the time-slot layer |
| rx_valid | input | 1 | Strobe for a byte received from the master |
| rx_byte | input | 8 | Received byte |
| tx_req | input | 1 | Request for the next byte to send to the master |
| prog_pulse | input | 1 | Programming pulse detected |
| tx_valid | output | 1 | Response to a tx request, one cycle after it |
| tx_byte | output | 8 | Byte to send |

## Verification
The assertions check several properties on every cycle. They confirm that array bits never go from 0 to 1, that status byte 7 stays 00h, and that a page whose protect bit is cleared never changes. They also confirm that each tx response lines up with its request, that a bus reset silences the next response, and that the trailing state only ever sends FFh. Other behaviour can only be shown by the bench's scenarios. This includes the CRC values and where they are inserted (per page, per field, and reseeded on each write pass), address masking, end-of-field handling, and the absence of a trailing CRC after an aborted read. The bench covers these by programming and reading back every data byte.

// File: rtl/otp_pkg.sv
package otp_pkg;

    localparam logic [7:0] OP_RD_MEM  = 8'hF0;
    localparam logic [7:0] OP_RD_PAGE = 8'hC3;
    localparam logic [7:0] OP_RD_STAT = 8'hAA;
    localparam logic [7:0] OP_WR_MEM  = 8'h0F;
    localparam logic [7:0] OP_WR_STAT = 8'h55;

    typedef enum logic [3:0] {
        S_CMD, S_ALO, S_AHI, S_HCRC, S_RD, S_RCRC,
        S_WDATA, S_WCRC, S_WPROG, S_WVFY, S_ONES
    } state_e;

    typedef enum logic [2:0] {
        K_NONE, K_RD_MEM, K_RD_PAGE, K_RD_STAT, K_WR_MEM, K_WR_STAT
    } kind_e;

    typedef struct packed {
        state_e      st;
        kind_e       kind;
        logic [15:0] addr;
        logic [7:0]  crc;
        logic [7:0]  pad;
        logic        tx_v;
        logic [7:0]  tx_b;
    } ctl_s;

endpackage

// File: rtl/otp_crc8.sv
module otp_crc8 (
    input  logic [7:0] crc_i,
    input  logic [7:0] byte_i,
    output logic [7:0] crc_o
);
    localparam logic [7:0] POLY_REFL = 8'h8C;

    always_comb begin
        logic [7:0] c;
        c = crc_i;
        for (int b = 0; b < 8; b++) begin
            if (c[0] ^ byte_i[b]) c = (c >> 1) ^ POLY_REFL;
            else                  c = c >> 1;
        end
        crc_o = c;
    end
endmodule

// File: rtl/otp_array.sv
module otp_array #(
    parameter int BYTES    = 128,
    parameter int ZERO_TOP = 0
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  we,
    input  logic [$clog2(BYTES)-1:0] waddr,
    input  logic [7:0]            wdata,
    output logic [BYTES*8-1:0]    bits_o
);
    localparam int AW = $clog2(BYTES);

    for (genvar i = 0; i < BYTES; i++) begin : g_byte
        localparam logic [7:0] INIT = (i >= BYTES - ZERO_TOP) ? 8'h00 : 8'hFF;
        logic [7:0] cell_q;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)                          cell_q <= INIT;
            else if (we && waddr == AW'(i))      cell_q <= cell_q & wdata;
        end
        assign bits_o[i*8 +: 8] = cell_q;
    end
endmodule

// File: rtl/otp_cmd_ctrl.sv
module otp_cmd_ctrl
    import otp_pkg::*;
#(
    parameter int DATA_BYTES = 128,
    parameter int PAGE_BYTES = 32,
    parameter int STAT_BYTES = 8
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       bus_reset,
    input  logic       rx_valid,
    input  logic [7:0] rx_byte,
    input  logic       tx_req,
    input  logic       prog_pulse,
    output logic       tx_valid,
    output logic [7:0] tx_byte
);
    localparam int DAW = $clog2(DATA_BYTES);
    localparam int SAW = $clog2(STAT_BYTES);
    localparam int PGW = $clog2(PAGE_BYTES);
    localparam logic [7:0]  DLOW_MASK = 8'(DATA_BYTES - 1);
    localparam logic [7:0]  SLOW_MASK = 8'(STAT_BYTES - 1);
    localparam logic [16:0] DSIZE = 17'(DATA_BYTES);
    localparam logic [16:0] SSIZE = 17'(STAT_BYTES);

    ctl_s q, d;

    logic [DATA_BYTES*8-1:0] data_flat;
    logic [STAT_BYTES*8-1:0] stat_flat;
    logic       data_we, stat_we;
    logic [7:0] crc_feed, crc_seed, crc_next;
    logic [7:0] rd_data, rd_stat, cur_byte;
    logic       is_stat, is_write;
    logic [16:0] fsize, nxt;
    logic [7:0] lo_mask;
    logic       page_locked;
    logic       st_is_ones;

    otp_array #(.BYTES(DATA_BYTES), .ZERO_TOP(0)) u_data (
        .clk(clk), .rst_n(rst_n), .we(data_we),
        .waddr(q.addr[DAW-1:0]), .wdata(q.pad), .bits_o(data_flat)
    );

    otp_array #(.BYTES(STAT_BYTES), .ZERO_TOP(1)) u_stat (
        .clk(clk), .rst_n(rst_n), .we(stat_we),
        .waddr(q.addr[SAW-1:0]), .wdata(q.pad), .bits_o(stat_flat)
    );

    otp_crc8 u_crc (.crc_i(crc_seed), .byte_i(crc_feed), .crc_o(crc_next));

    // field geometry and read mux
    always_comb begin
        is_stat     = (q.kind == K_RD_STAT) || (q.kind == K_WR_STAT);
        is_write    = (q.kind == K_WR_MEM)  || (q.kind == K_WR_STAT);
        fsize       = is_stat ? SSIZE : DSIZE;
        nxt         = {1'b0, q.addr} + 17'd1;
        rd_data     = data_flat[8*int'(q.addr[DAW-1:0]) +: 8];
        rd_stat     = stat_flat[8*int'(q.addr[SAW-1:0]) +: 8];
        cur_byte    = is_stat ? rd_stat : rd_data;
        lo_mask     = (q.kind == K_WR_MEM)  ? DLOW_MASK :
                      (q.kind == K_WR_STAT) ? SLOW_MASK : 8'hFF;
        page_locked = !stat_flat[int'(q.addr[DAW-1:PGW])];
        st_is_ones  = (q.st == S_ONES);
    end

    // CRC input selection
    always_comb begin
        crc_seed = q.crc;
        crc_feed = rx_byte;
        case (q.st)
            S_CMD:   crc_seed = 8'h00;
            S_ALO:   crc_feed = rx_byte & lo_mask;
            S_AHI:   crc_feed = is_write ? 8'h00 : rx_byte;
            S_RD:    crc_feed = cur_byte;
            default: crc_feed = rx_byte;
        endcase
    end

    // next-state logic
    always_comb begin
        d       = q;
        d.tx_v  = 1'b0;
        data_we = 1'b0;
        stat_we = 1'b0;
        if (tx_req) begin
            d.tx_v = 1'b1;
            d.tx_b = 8'hFF;
        end
        case (q.st)
            S_CMD: if (rx_valid) begin
                case (rx_byte)
                    OP_RD_MEM:  d.kind = K_RD_MEM;
                    OP_RD_PAGE: d.kind = K_RD_PAGE;
                    OP_RD_STAT: d.kind = K_RD_STAT;
                    OP_WR_MEM:  d.kind = K_WR_MEM;
                    OP_WR_STAT: d.kind = K_WR_STAT;
                    default:    d.kind = K_NONE;
                endcase
                d.crc = crc_next;
                d.st  = (d.kind == K_NONE) ? S_ONES : S_ALO;
            end
            S_ALO: if (rx_valid) begin
                d.addr[7:0] = rx_byte & lo_mask;
                d.crc       = crc_next;
                d.st        = S_AHI;
            end
            S_AHI: if (rx_valid) begin
                d.addr[15:8] = is_write ? 8'h00 : rx_byte;
                d.crc        = crc_next;
                d.st         = is_write ? S_WDATA : S_HCRC;
            end
            S_HCRC: if (tx_req) begin
                d.tx_b = q.crc;
                d.crc  = 8'h00;
                d.st   = ({1'b0, q.addr} < fsize) ? S_RD : S_ONES;
            end
            S_RD: if (tx_req) begin
                d.tx_b = cur_byte;
                d.crc  = crc_next;
                d.addr = nxt[15:0];
                if (q.kind == K_RD_PAGE) begin
                    if (nxt[PGW-1:0] == '0) d.st = S_RCRC;
                end else if (nxt == fsize) begin
                    d.st = S_RCRC;
                end
            end
            S_RCRC: if (tx_req) begin
                d.tx_b = q.crc;
                d.crc  = 8'h00;
                d.st   = (q.kind == K_RD_PAGE && {1'b0, q.addr} < fsize) ? S_RD : S_ONES;
            end
            S_WDATA: if (rx_valid) begin
                d.pad = rx_byte;
                d.crc = crc_next;
                d.st  = S_WCRC;
            end
            S_WCRC: if (tx_req) begin
                d.tx_b = q.crc;
                d.st   = S_WPROG;
            end
            S_WPROG: if (prog_pulse) begin
                data_we = (q.kind == K_WR_MEM) && !page_locked;
                stat_we = (q.kind == K_WR_STAT);
                d.st    = S_WVFY;
            end
            S_WVFY: if (tx_req) begin
                d.tx_b = cur_byte;
                d.addr = nxt[15:0];
                if (nxt == fsize) begin
                    d.st = S_ONES;
                end else begin
                    d.crc = nxt[7:0];
                    d.st  = S_WDATA;
                end
            end
            default: ;
        endcase
        if (bus_reset) begin
            d.st    = S_CMD;
            d.kind  = K_NONE;
            d.crc   = 8'h00;
            d.tx_v  = 1'b0;
            data_we = 1'b0;
            stat_we = 1'b0;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            q      <= '0;
            q.st   <= S_CMD;
            q.kind <= K_NONE;
        end else begin
            q <= d;
        end
    end

    assign tx_valid = q.tx_v;
    assign tx_byte  = q.tx_b;

endmodule

// File: rtl/otp_cmd_ctrl_chk.sv
module otp_cmd_ctrl_chk #(
    parameter int DATA_BYTES = 128,
    parameter int PAGE_BYTES = 32,
    parameter int STAT_BYTES = 8
) (
    input logic                  clk,
    input logic                  rst_n,
    input logic                  bus_reset,
    input logic                  tx_req,
    input logic                  tx_valid,
    input logic [7:0]            tx_byte,
    input logic [DATA_BYTES*8-1:0] data_flat,
    input logic [STAT_BYTES*8-1:0] stat_flat,
    input logic                  in_ones
);
    localparam int PAGES = DATA_BYTES / PAGE_BYTES;

    AST_TX_NEEDS_REQ: assert property (@(posedge clk) disable iff (!rst_n)
        tx_valid |-> $past(tx_req)); // R12

    AST_REQ_ANSWERED: assert property (@(posedge clk) disable iff (!rst_n)
        (tx_req && !bus_reset) |=> tx_valid); // R12

    AST_BUSRST_SILENT: assert property (@(posedge clk) disable iff (!rst_n)
        bus_reset |=> !tx_valid); // R11

    AST_DATA_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (data_flat & ~$past(data_flat)) == '0); // R7

    AST_STAT_ONLY_CLEARS: assert property (@(posedge clk) disable iff (!rst_n)
        (stat_flat & ~$past(stat_flat)) == '0); // R7

    AST_STAT_TOP_ZERO: assert property (@(posedge clk) disable iff (!rst_n)
        stat_flat[STAT_BYTES*8-1 -: 8] == 8'h00); // R5

    AST_ONES_FILL: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(in_ones) && tx_valid) |-> tx_byte == 8'hFF); // R1

    for (genvar p = 0; p < PAGES; p++) begin : g_lock
        AST_PAGE_LOCKED: assert property (@(posedge clk) disable iff (!rst_n)
            !$past(stat_flat[p]) |-> $stable(data_flat[p*PAGE_BYTES*8 +: PAGE_BYTES*8])); // R9
    end
endmodule

bind otp_cmd_ctrl otp_cmd_ctrl_chk #(
    .DATA_BYTES(DATA_BYTES), .PAGE_BYTES(PAGE_BYTES), .STAT_BYTES(STAT_BYTES)
) u_chk (
    .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .tx_req(tx_req),
    .tx_valid(tx_valid), .tx_byte(tx_byte), .data_flat(data_flat),
    .stat_flat(stat_flat), .in_ones(st_is_ones)
);

// File: tb/otp_cmd_ctrl_test.sv
`timescale 1ns/1ps
module otp_cmd_ctrl_test;
    logic clk = 1'b0, rst_n = 1'b0, bus_reset = 1'b0;
    logic rx_valid = 1'b0, tx_req = 1'b0, prog_pulse = 1'b0;
    logic [7:0] rx_byte = 8'h00;
    logic tx_valid;
    logic [7:0] tx_byte;
    int checks = 0, errors = 0;
    logic [7:0] mdl_data [128];
    logic [7:0] mdl_stat [8];

    otp_cmd_ctrl uut (
        .clk(clk), .rst_n(rst_n), .bus_reset(bus_reset), .rx_valid(rx_valid),
        .rx_byte(rx_byte), .tx_req(tx_req), .prog_pulse(prog_pulse),
        .tx_valid(tx_valid), .tx_byte(tx_byte)
    );

    always #5 clk = ~clk;

    function automatic logic [7:0] crc_b(input logic [7:0] c, input logic [7:0] b);
        logic [7:0] r;
        r = c;
        for (int i = 0; i < 8; i++) r = (r[0] ^ b[i]) ? ((r >> 1) ^ 8'h8C) : (r >> 1);
        return r;
    endfunction

    function automatic logic [7:0] pat(input int i);
        return 8'((i * 37) ^ 8'h5A);
    endfunction

    task automatic chk(input string tag, input logic [7:0] act, input logic [7:0] exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s act=%h exp=%h", tag, act, exp);
        end
    endtask

    task automatic put(input logic [7:0] b);
        @(negedge clk); rx_byte = b; rx_valid = 1'b1;
        @(negedge clk); rx_valid = 1'b0;
    endtask

    task automatic get(output logic [7:0] b);
        @(negedge clk); tx_req = 1'b1;
        @(negedge clk); tx_req = 1'b0;
        if (tx_valid !== 1'b1) begin
            checks++; errors++;
            $display("FAIL R12 tx_valid act=%b exp=1", tx_valid);
        end
        b = tx_byte;
    endtask

    task automatic prog();
        @(negedge clk); prog_pulse = 1'b1;
        @(negedge clk); prog_pulse = 1'b0;
    endtask

    task automatic brst();
        @(negedge clk); bus_reset = 1'b1;
        @(negedge clk); bus_reset = 1'b0;
    endtask

    // header of a read command: returns the CRC check
    task automatic rd_hdr(input logic [7:0] op, input logic [7:0] lo, input logic [7:0] hi, input string tag);
        logic [7:0] b;
        put(op); put(lo); put(hi);
        get(b);
        chk(tag, b, crc_b(crc_b(crc_b(8'h00, op), lo), hi));
    endtask

    // one write pass: data, CRC, optional pulse, verify
    task automatic wr_pass(input logic [7:0] exp_crc, input logic [7:0] dat,
                           input logic [7:0] exp_vfy, input string tag);
        logic [7:0] b;
        put(dat);
        get(b); chk({tag, " crc"}, b, exp_crc);
        prog();
        get(b); chk({tag, " verify"}, b, exp_vfy);
    endtask

    initial begin
        #2_000_000;
        errors++; checks++;
        $display("FAIL watchdog act=timeout exp=finish");
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        logic [7:0] b, c, h;
        for (int i = 0; i < 128; i++) mdl_data[i] = 8'hFF;
        for (int i = 0; i < 7; i++) mdl_stat[i] = 8'hFF;
        mdl_stat[7] = 8'h00;
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R12 reset tx_valid", {7'd0, tx_valid}, 8'h00);
        get(b); chk("R12 idle request", b, 8'hFF);

        // R5: fresh status read
        rd_hdr(8'hAA, 8'h00, 8'h00, "R2 status header");
        c = 8'h00;
        for (int i = 0; i < 8; i++) begin
            get(b); chk("R5 status byte", b, mdl_stat[i]); c = crc_b(c, mdl_stat[i]);
        end
        get(b); chk("R5 status crc", b, c);
        get(b); chk("R5 ones after crc", b, 8'hFF);
        brst();

        // R6 R8: program every data byte in one sequence
        put(8'h0F); put(8'h00); put(8'h00);
        for (int i = 0; i < 128; i++) begin
            h = (i == 0) ? crc_b(crc_b(crc_b(crc_b(8'h00, 8'h0F), 8'h00), 8'h00), pat(i))
                         : crc_b(8'(i), pat(i));
            mdl_data[i] = mdl_data[i] & pat(i);
            wr_pass(h, pat(i), mdl_data[i], i == 0 ? "R6 first pass" : "R8 later pass");
        end
        get(b); chk("R8 ones past end", b, 8'hFF);
        brst();

        // R7: AND accumulation on a second programming
        put(8'h0F); put(8'h10); put(8'h00);
        h = crc_b(crc_b(crc_b(crc_b(8'h00, 8'h0F), 8'h10), 8'h00), 8'h3C);
        mdl_data[16] = mdl_data[16] & 8'h3C;
        wr_pass(h, 8'h3C, mdl_data[16], "R7 and accumulate");
        wr_pass(crc_b(8'h11, 8'hFF), 8'hFF, mdl_data[17], "R7 ff keeps");
        brst();

        // R6: masked address 01A5h -> 25h
        put(8'h0F); put(8'hA5); put(8'h01);
        h = crc_b(crc_b(crc_b(crc_b(8'h00, 8'h0F), 8'h25), 8'h00), 8'h0F);
        mdl_data[37] = mdl_data[37] & 8'h0F;
        wr_pass(h, 8'h0F, mdl_data[37], "R6 masked address");
        brst();

        // R7: pulses outside the program-wait state do nothing
        put(8'h0F); put(8'h30); put(8'h00);
        prog();
        put(8'h00);
        prog();
        get(b);
        brst();
        rd_hdr(8'hF0, 8'h30, 8'h00, "R2 read header");
        get(b); chk("R7 stray pulse ignored", b, mdl_data[48]);
        brst();

        // R9 R10: protect page 2, redirect page 1
        put(8'h55); put(8'h00); put(8'h00);
        h = crc_b(crc_b(crc_b(crc_b(8'h00, 8'h55), 8'h00), 8'h00), 8'hFB);
        mdl_stat[0] = 8'hFB;
        wr_pass(h, 8'hFB, 8'hFB, "R9 set protect");
        mdl_stat[1] = 8'hFD;
        wr_pass(crc_b(8'h01, 8'hFD), 8'hFD, 8'hFD, "R10 set redirect");
        brst();
        put(8'h0F); put(8'h45); put(8'h00);
        h = crc_b(crc_b(crc_b(crc_b(8'h00, 8'h0F), 8'h45), 8'h00), 8'h00);
        wr_pass(h, 8'h00, mdl_data[69], "R9 locked page");
        brst();
        put(8'h0F); put(8'h22); put(8'h00);
        h = crc_b(crc_b(crc_b(crc_b(8'h00, 8'h0F), 8'h22), 8'h00), 8'h0F);
        mdl_data[34] = mdl_data[34] & 8'h0F;
        wr_pass(h, 8'h0F, mdl_data[34], "R10 redirected page writable");
        brst();

        // R5 R8: status byte 7 stays zero, end of status field
        put(8'h55); put(8'hFF); put(8'h00);
        h = crc_b(crc_b(crc_b(crc_b(8'h00, 8'h55), 8'h07), 8'h00), 8'hFF);
        wr_pass(h, 8'hFF, 8'h00, "R5 status top");
        get(b); chk("R8 status end ones", b, 8'hFF);
        brst();

        // R3: full data read and tail read
        rd_hdr(8'hF0, 8'h00, 8'h00, "R2 read header");
        c = 8'h00;
        for (int i = 0; i < 128; i++) begin
            get(b); chk("R3 data byte", b, mdl_data[i]); c = crc_b(c, mdl_data[i]);
        end
        get(b); chk("R3 trailing crc", b, c);
        get(b); chk("R3 ones", b, 8'hFF);
        brst();
        rd_hdr(8'hF0, 8'h7E, 8'h00, "R2 read header");
        get(b); chk("R3 tail byte", b, mdl_data[126]);
        get(b); chk("R3 tail byte", b, mdl_data[127]);
        get(b); chk("R3 tail crc", b, crc_b(crc_b(8'h00, mdl_data[126]), mdl_data[127]));
        brst();
        rd_hdr(8'hF0, 8'h80, 8'h00, "R2 read header raw");
        get(b); chk("R3 start past end", b, 8'hFF);
        brst();

        // R4: page-framed reads, full and from mid-page
        rd_hdr(8'hC3, 8'h00, 8'h00, "R2 page header");
        for (int p = 0; p < 4; p++) begin
            c = 8'h00;
            for (int i = 0; i < 32; i++) begin
                get(b); chk("R4 page byte", b, mdl_data[p*32+i]); c = crc_b(c, mdl_data[p*32+i]);
            end
            get(b); chk("R4 page crc", b, c);
        end
        get(b); chk("R4 ones", b, 8'hFF);
        brst();
        rd_hdr(8'hC3, 8'h1C, 8'h00, "R2 page header");
        c = 8'h00;
        for (int i = 28; i < 32; i++) begin
            get(b); chk("R4 partial byte", b, mdl_data[i]); c = crc_b(c, mdl_data[i]);
        end
        get(b); chk("R4 partial crc", b, c);
        c = 8'h00;
        for (int i = 32; i < 64; i++) begin
            get(b); chk("R4 next page byte", b, mdl_data[i]); c = crc_b(c, mdl_data[i]);
        end
        get(b); chk("R4 next page crc", b, c);
        brst();

        // R5: status read from mid field
        rd_hdr(8'hAA, 8'h05, 8'h00, "R2 status header");
        c = 8'h00;
        for (int i = 5; i < 8; i++) begin
            get(b); chk("R5 status tail", b, mdl_stat[i]); c = crc_b(c, mdl_stat[i]);
        end
        get(b); chk("R5 status tail crc", b, c);
        brst();

        // R11: abort before trailing CRC; reset with request in same cycle
        rd_hdr(8'hF0, 8'h7E, 8'h00, "R2 read header");
        get(b); get(b);
        brst();
        get(b); chk("R11 no crc after abort", b, 8'hFF);
        @(negedge clk); bus_reset = 1'b1; tx_req = 1'b1;
        @(negedge clk); bus_reset = 1'b0; tx_req = 1'b0;
        chk("R11 silent on reset", {7'd0, tx_valid}, 8'h00);
        rd_hdr(8'hAA, 8'h03, 8'h00, "R11 fresh command");
        brst();

        // R1: unknown command
        put(8'h99); put(8'h00); put(8'h00);
        get(b); chk("R1 unknown ones", b, 8'hFF);
        get(b); chk("R1 unknown ones", b, 8'hFF);
        brst();
        rd_hdr(8'hF0, 8'h05, 8'h00, "R1 recovers");
        get(b); chk("R1 data after recover", b, mdl_data[5]);

        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end
endmodule